// File: doc/BRIEF.md
# Two-Base Section and Page Table Walker

This block resolves one 32-bit virtual address at a time into a physical address by reading descriptors from in-memory translation tables. It holds two table base registers and a split count n. Addresses whose top n bits are all zero are walked from the low table. All other addresses are walked from the high table. This lets a per-process table cover the bottom of the address space while a shared table covers the top.

The first-level read returns one of three results. It can be a fault. It can be a 1 MB section, which ends the walk after that single read. It can be a pointer to a second-level table, in which case a second read fetches a 4 KB page descriptor. The block reports the physical address, a two-bit permission field and a fault flag.

A requester offers an address with a valid/ready handshake. The walker issues memory reads through a request channel with valid/ready and a response channel with valid only. Only one walk is in flight at a time.

Top module: `dbw_walker`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `mem_req_valid_o` and `res_valid_o` are 0. All three configuration registers read as zero, so a walk started straight after reset reads its first descriptor from address `{va[31:20], 2'b00}`.
- R2: With split count n, the walk uses base 0 when bits [31:32-n] of the address are all zero, and base 1 otherwise. When n is 0, base 0 is always used.
- R3: The first-level read address is built from the selected base with its low bits cleared, OR-ed with the table index shifted left by 2. For base 1, bits [13:0] of the base are cleared and the index is the full `va[31:20]`. For base 0, bits [13-n:0] of the base are cleared and the index is the low 12-n bits of `va[31:20]`.
- R4: Bits [1:0] of a first-level descriptor select its kind: 00 is a fault, 01 is a second-level table pointer, 10 is a section, and 11 is a fault.
- R5: For a section, the walk ends after one read. The result is `pa = {desc[31:20], va[19:0]}` and `perm = desc[11:10]`.
- R6: For a table pointer, a second read is issued at `{desc[31:10], va[19:12], 2'b00}`. If that descriptor has bits [1:0] equal to 10, the result is `pa = {d2[31:12], va[11:0]}` and `perm = d2[5:4]`. Any other value of bits [1:0] is a fault.
- R7: A fault sets `res_fault_o` to 1 and forces `res_pa_o` and `res_perm_o` to zero. No further read is issued after a fault.
- R8: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the request and its address stay unchanged. The walker waits any number of cycles for `mem_rsp_valid_i`, which must come at least one cycle after the request is taken.
- R9: From acceptance until the result, `req_ready_o` is 0 and new requests are ignored. `res_valid_o` is a single-cycle pulse in the cycle after the final response. `req_ready_o` returns to 1 in the following cycle.
- R10: A write with `cfg_we_i` updates a configuration register: select 0 writes base 0, select 1 writes base 1, select 2 writes n from the low 3 bits. The first-level address is fixed when a walk is accepted, so a write during a walk does not change that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Register select: 0 base 0, 1 base 1, 2 split count |
| cfg_wdata_i | input | 32 | Configuration write data |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle and able to accept |
| req_va_i | input | 32 | Virtual address to translate |
| mem_req_valid_o | output | 1 | Descriptor read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read request |
| mem_req_addr_o | output | 32 | Descriptor byte address |
| mem_rsp_valid_i | input | 1 | Descriptor data valid |
| mem_rsp_data_i | input | 32 | Descriptor data |
| res_valid_o | output | 1 | Result pulse |
| res_fault_o | output | 1 | Translation fault |
| res_pa_o | output | 32 | Physical address |
| res_perm_o | output | 2 | Permission bits from the final descriptor |

## Verification
The bench probes the base choice right at the split boundary. At n = 7, one address has only bit 24 set and another has bit 25 set. A comparison that used the wrong bit count would send both to the same base. Misaligned base values check that low base bits are cleared according to n. A design that OR-ed them in would read the wrong descriptor address.

Both reserved first-level kinds and an invalid second-level kind must produce a fault with a zeroed result and no extra read. A decoder that treated 11 as a section would instead return a physical address. Stalls on request ready and on the response check that the address holds steady. A configuration write and a second request made during a walk check that the walk in flight keeps its own address and that no second walk starts.

// File: rtl/dbw_pkg.sv
package dbw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } walk_st_e;

  typedef enum logic [1:0] {
    L1_FAULT   = 2'b00,
    L1_TABLE   = 2'b01,
    L1_SECTION = 2'b10,
    L1_RSVD    = 2'b11
  } l1_kind_e;

  localparam logic [1:0] L2_SMALL = 2'b10;

  localparam logic [1:0] CFG_BASE0 = 2'd0;
  localparam logic [1:0] CFG_BASE1 = 2'd1;
  localparam logic [1:0] CFG_SPLIT = 2'd2;

  localparam int SECT_AP_LSB = 10;
  localparam int PAGE_AP_LSB = 4;
endpackage

// File: rtl/dbw_cfg_regs.sv
module dbw_cfg_regs #(
  parameter int ADDR_W = 32,
  parameter int N_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] base0_o,
  output logic [ADDR_W-1:0] base1_o,
  output logic [N_W-1:0]    split_o
);
  import dbw_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base0_o <= '0;
      base1_o <= '0;
      split_o <= '0;
    end else if (we_i) begin
      case (sel_i)
        CFG_BASE0: base0_o <= wdata_i;
        CFG_BASE1: base1_o <= wdata_i;
        CFG_SPLIT: split_o <= wdata_i[N_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dbw_base_sel.sv
module dbw_base_sel #(
  parameter int ADDR_W = 32,
  parameter int SECT_W = 12,
  parameter int N_W    = 3
) (
  input  logic [ADDR_W-1:0] va_i,
  input  logic [ADDR_W-1:0] base0_i,
  input  logic [ADDR_W-1:0] base1_i,
  input  logic [N_W-1:0]    split_i,
  output logic              use_hi_o,
  output logic [ADDR_W-1:0] l1_addr_o
);
  localparam int SH_W     = $clog2(ADDR_W) + 1;
  localparam int L1_ALIGN = SECT_W + 2;
  localparam int PAD_W    = ADDR_W - SECT_W - 2;

  logic [ADDR_W-1:0] hi_mask, align_mask, base;
  logic [N_W-1:0]    sh;
  logic [SECT_W-1:0] idx;

  always_comb begin
    hi_mask    = ~({ADDR_W{1'b1}} >> split_i);
    use_hi_o   = |(va_i & hi_mask);
    sh         = use_hi_o ? '0 : split_i;
    idx        = va_i[ADDR_W-1 -: SECT_W] & ({SECT_W{1'b1}} >> sh);
    align_mask = {ADDR_W{1'b1}} << (SH_W'(L1_ALIGN) - SH_W'(sh));
    base       = use_hi_o ? base1_i : base0_i;
    l1_addr_o  = (base & align_mask) | {{PAD_W{1'b0}}, idx, 2'b00};
  end
endmodule

// File: rtl/dbw_desc_decode.sv
module dbw_desc_decode #(
  parameter int ADDR_W = 32,
  parameter int SECT_W = 12,
  parameter int PAGE_W = 12,
  parameter int PERM_W = 2
) (
  input  logic [ADDR_W-1:0]    va_i,
  input  logic [ADDR_W-1:0]    desc_i,
  output dbw_pkg::l1_kind_e    l1_kind_o,
  output logic [ADDR_W-1:0]    sect_pa_o,
  output logic [PERM_W-1:0]    sect_perm_o,
  output logic [ADDR_W-1:0]    l2_addr_o,
  output logic                 page_ok_o,
  output logic [ADDR_W-1:0]    page_pa_o,
  output logic [PERM_W-1:0]    page_perm_o
);
  import dbw_pkg::*;

  localparam int OFF_W    = ADDR_W - SECT_W;
  localparam int L2_IDX_W = OFF_W - PAGE_W;
  localparam int L2_ALIGN = L2_IDX_W + 2;

  always_comb begin
    l1_kind_o   = l1_kind_e'(desc_i[1:0]);
    sect_pa_o   = {desc_i[ADDR_W-1 -: SECT_W], va_i[OFF_W-1:0]};
    sect_perm_o = desc_i[SECT_AP_LSB +: PERM_W];
    l2_addr_o   = {desc_i[ADDR_W-1:L2_ALIGN], va_i[OFF_W-1:PAGE_W], 2'b00};
    page_ok_o   = (desc_i[1:0] == L2_SMALL);
    page_pa_o   = {desc_i[ADDR_W-1:PAGE_W], va_i[PAGE_W-1:0]};
    page_perm_o = desc_i[PAGE_AP_LSB +: PERM_W];
  end
endmodule

// File: rtl/dbw_walker.sv
module dbw_walker #(
  parameter int ADDR_W = 32,
  parameter int SECT_W = 12,
  parameter int PAGE_W = 12,
  parameter int N_W    = 3,
  parameter int PERM_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_va_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [ADDR_W-1:0] mem_rsp_data_i,
  output logic              res_valid_o,
  output logic              res_fault_o,
  output logic [ADDR_W-1:0] res_pa_o,
  output logic [PERM_W-1:0] res_perm_o
);
  import dbw_pkg::*;

  walk_st_e          state_q;
  logic [ADDR_W-1:0] va_q, addr_q, pa_q;
  logic [PERM_W-1:0] perm_q;
  logic              fault_q;

  logic [ADDR_W-1:0] base0, base1, l1_addr;
  logic [N_W-1:0]    split;
  logic              use_hi;

  l1_kind_e          l1_kind;
  logic [ADDR_W-1:0] sect_pa, l2_addr, page_pa;
  logic [PERM_W-1:0] sect_perm, page_perm;
  logic              page_ok;

  dbw_cfg_regs #(.ADDR_W(ADDR_W), .N_W(N_W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .sel_i(cfg_sel_i),
    .wdata_i(cfg_wdata_i), .base0_o(base0), .base1_o(base1), .split_o(split)
  );

  dbw_base_sel #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .N_W(N_W)) u_sel (
    .va_i(req_va_i), .base0_i(base0), .base1_i(base1), .split_i(split),
    .use_hi_o(use_hi), .l1_addr_o(l1_addr)
  );

  dbw_desc_decode #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .PAGE_W(PAGE_W),
                    .PERM_W(PERM_W)) u_dec (
    .va_i(va_q), .desc_i(mem_rsp_data_i), .l1_kind_o(l1_kind),
    .sect_pa_o(sect_pa), .sect_perm_o(sect_perm), .l2_addr_o(l2_addr),
    .page_ok_o(page_ok), .page_pa_o(page_pa), .page_perm_o(page_perm)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      addr_q  <= '0;
      pa_q    <= '0;
      perm_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          va_q    <= req_va_i;
          addr_q  <= l1_addr;  // base chosen at acceptance
          state_q <= ST_L1_REQ;
        end
        ST_L1_REQ: if (mem_req_ready_i) state_q <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rsp_valid_i) begin
          case (l1_kind)
            L1_SECTION: begin
              pa_q    <= sect_pa;
              perm_q  <= sect_perm;
              fault_q <= 1'b0;
              state_q <= ST_DONE;
            end
            L1_TABLE: begin
              addr_q  <= l2_addr;
              state_q <= ST_L2_REQ;
            end
            default: begin
              pa_q    <= '0;
              perm_q  <= '0;
              fault_q <= 1'b1;
              state_q <= ST_DONE;
            end
          endcase
        end
        ST_L2_REQ: if (mem_req_ready_i) state_q <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rsp_valid_i) begin
          pa_q    <= page_ok ? page_pa : '0;
          perm_q  <= page_ok ? page_perm : '0;
          fault_q <= !page_ok;
          state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign mem_req_addr_o  = addr_q;
  assign res_valid_o     = (state_q == ST_DONE);
  assign res_fault_o     = fault_q;
  assign res_pa_o        = pa_q;
  assign res_perm_o      = perm_q;

  // R8: request held with its address until taken
  a_r8_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  // R9: result is a one-cycle pulse, then idle
  a_r9_res_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o && req_ready_o);

  // R9: no read while idle, so never two walks
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_valid_o && !res_valid_o);

  // R7: faults carry zero address and permission
  a_r7_fault_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_fault_o |-> res_pa_o == '0 && res_perm_o == '0);

  // R2: zero split never selects the high base
  a_r2_split0_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    split == '0 |-> !use_hi);

  // R6: second-level read only follows a table-pointer response
  a_r6_l2_after_l1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_L2_REQ) |-> $past(state_q) == ST_L1_WAIT
                                    && $past(l1_kind) == L1_TABLE);

  // R10: walk address frozen while busy
  a_r10_va_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o && !res_valid_o |=> $stable(va_q));
endmodule

// File: tb/sim_dbw_walker.sv
module sim_dbw_walker;
  localparam int CLK_P = 10;
  localparam int NV    = 14;

  typedef struct packed {
    logic [2:0]  n;
    logic [31:0] b0, b1, va, a1, d1, a2, d2, pa;
    logic [1:0]  perm;
    logic        flt;
    logic [1:0]  nrd, rw, sw;
  } vec_t;

  // n, base0, base1, va, l1 addr, l1 desc, l2 addr, l2 desc, pa, perm, fault, reads, ready stall, rsp stall
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'h00010000, 32'h00020000, 32'h12345678, 32'h0001048C, 32'h8AB00C02, 32'h0, 32'h0, 32'h8AB45678, 2'd3, 1'b0, 2'd1, 2'd0, 2'd0}, // R5
    '{3'd0, 32'h00010000, 32'h00020000, 32'h00401ABC, 32'h00010010, 32'h00030401, 32'h00030404, 32'h76543022, 32'h76543ABC, 2'd2, 1'b0, 2'd2, 2'd1, 2'd2}, // R6
    '{3'd0, 32'h00010000, 32'h00020000, 32'hFFF00000, 32'h00013FFC, 32'h00000000, 32'h0, 32'h0, 32'h0, 2'd0, 1'b1, 2'd1, 2'd2, 2'd0}, // R4 type 00, R2 n=0
    '{3'd0, 32'h00010000, 32'h00020000, 32'h00502000, 32'h00010014, 32'h00030801, 32'h00030808, 32'h12345001, 32'h0, 2'd0, 1'b1, 2'd2, 2'd0, 2'd1}, // R6 bad l2
    '{3'd0, 32'h00010000, 32'h00020000, 32'h00600000, 32'h00010018, 32'hABC00003, 32'h0, 32'h0, 32'h0, 2'd0, 1'b1, 2'd1, 2'd0, 2'd0}, // R4 type 11
    '{3'd0, 32'h00012FFF, 32'h00020000, 32'h00800000, 32'h00010020, 32'h44400002, 32'h0, 32'h0, 32'h44400000, 2'd0, 1'b0, 2'd1, 2'd3, 2'd3}, // R3 align
    '{3'd2, 32'h00010000, 32'h00020000, 32'h3FF00123, 32'h00010FFC, 32'h55500402, 32'h0, 32'h0, 32'h55500123, 2'd1, 1'b0, 2'd1, 2'd0, 2'd0}, // R2 low
    '{3'd2, 32'h00010000, 32'h00020000, 32'h40100000, 32'h00021004, 32'h99900802, 32'h0, 32'h0, 32'h99900000, 2'd2, 1'b0, 2'd1, 2'd1, 2'd1}, // R2 high
    '{3'd2, 32'h00010000, 32'h00020000, 32'hC0005FFF, 32'h00023000, 32'h00040001, 32'h00040014, 32'hFFFFF032, 32'hFFFFFFFF, 2'd3, 1'b0, 2'd2, 2'd2, 2'd0}, // R6 via base1
    '{3'd2, 32'h00011FFC, 32'h00020ABC, 32'h80000004, 32'h00022000, 32'h12300C02, 32'h0, 32'h0, 32'h12300004, 2'd3, 1'b0, 2'd1, 2'd0, 2'd2}, // R3 base1 align
    '{3'd2, 32'h00011FFC, 32'h00020000, 32'h00200000, 32'h00011008, 32'h33300002, 32'h0, 32'h0, 32'h33300000, 2'd0, 1'b0, 2'd1, 2'd0, 2'd0}, // R3 base0 align n=2
    '{3'd7, 32'h00010000, 32'h00020000, 32'h01000000, 32'h00010040, 32'h22200402, 32'h0, 32'h0, 32'h22200000, 2'd1, 1'b0, 2'd1, 2'd0, 2'd0}, // R2 edge low
    '{3'd7, 32'h00010000, 32'h00020000, 32'h02100000, 32'h00020084, 32'h66600002, 32'h0, 32'h0, 32'h66600000, 2'd0, 1'b0, 2'd1, 2'd0, 2'd0}, // R2 edge high
    '{3'd0, 32'h00010000, 32'h00020000, 32'h00A03000, 32'h00010028, 32'h00050001, 32'h0005000C, 32'h1111F003, 32'h0, 2'd0, 1'b1, 2'd2, 2'd0, 2'd0}  // R6 l2 type 11
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic        mem_req_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        req_ready_o, mem_req_valid_o, res_valid_o, res_fault_o;
  logic [31:0] mem_req_addr_o, res_pa_o;
  logic [1:0]  res_perm_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  dbw_walker u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .req_valid_i(req_valid), .req_ready_o(req_ready_o),
    .req_va_i(req_va), .mem_req_valid_o(mem_req_valid_o),
    .mem_req_ready_i(mem_req_ready), .mem_req_addr_o(mem_req_addr_o),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data),
    .res_valid_o(res_valid_o), .res_fault_o(res_fault_o),
    .res_pa_o(res_pa_o), .res_perm_o(res_perm_o)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_cfg(input vec_t v);
    cfg_write(2'd0, v.b0);
    cfg_write(2'd1, v.b1);
    cfg_write(2'd2, {29'd0, v.n});
  endtask

  task automatic do_walk(input vec_t v, input string tag);
    int  nreads;
    logic done;
    logic [31:0] ea;
    nreads = 0;
    done = 1'b0;
    @(negedge clk);
    chk(req_ready_o === 1'b1, {tag, " R9 idle ready"}, {31'd0, req_ready_o}, 32'd1);
    req_valid = 1'b1; req_va = v.va;
    @(negedge clk);
    req_valid = 1'b0;
    for (int rd = 0; rd < 3 && !done; rd++) begin
      if (res_valid_o) begin
        done = 1'b1;
      end else begin
        ea = (rd == 0) ? v.a1 : v.a2;
        chk(mem_req_valid_o === 1'b1, {tag, " R8 read issued"}, {31'd0, mem_req_valid_o}, 32'd1);
        chk(mem_req_addr_o === ea, {tag, (rd == 0) ? " R3 l1 addr" : " R6 l2 addr"},
            mem_req_addr_o, ea);
        for (int s = 0; s < int'(v.rw); s++) begin
          @(negedge clk);
          chk(mem_req_valid_o === 1'b1 && mem_req_addr_o === ea, {tag, " R8 hold"},
              mem_req_addr_o, ea);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk(!mem_req_valid_o && !req_ready_o, {tag, " R9 busy"},
            {30'd0, mem_req_valid_o, req_ready_o}, 32'd0);
        for (int s = 0; s < int'(v.sw); s++) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = (rd == 0) ? v.d1 : v.d2;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        nreads++;
      end
    end
    chk(done, {tag, " R9 result"}, {31'd0, done}, 32'd1);
    chk(nreads == int'(v.nrd), {tag, " R5 R7 read count"}, nreads, {30'd0, v.nrd});
    chk(res_fault_o === v.flt, {tag, " R4 R7 fault"}, {31'd0, res_fault_o}, {31'd0, v.flt});
    chk(res_pa_o === v.pa, {tag, " R5 R6 pa"}, res_pa_o, v.pa);
    chk(res_perm_o === v.perm, {tag, " R5 R6 perm"}, {30'd0, res_perm_o}, {30'd0, v.perm});
    @(negedge clk);
    chk(!res_valid_o && req_ready_o, {tag, " R9 pulse end"},
        {30'd0, res_valid_o, req_ready_o}, 32'd1);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready_o === 1'b1, "R1 ready", {31'd0, req_ready_o}, 32'd1);
    chk(mem_req_valid_o === 1'b0, "R1 mem idle", {31'd0, mem_req_valid_o}, 32'd0);
    chk(res_valid_o === 1'b0, "R1 no result", {31'd0, res_valid_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: zero config, base 0 at address 0
    v = '{3'd0, 32'h0, 32'h0, 32'h00300000, 32'h0000000C, 32'h00100002, 32'h0, 32'h0,
          32'h00100000, 2'd0, 1'b0, 2'd1, 2'd0, 2'd0};
    do_walk(v, "R1 zero cfg");

    for (int i = 0; i < NV; i++) begin
      set_cfg(VECS[i]);
      do_walk(VECS[i], $sformatf("vec%0d", i));
    end

    // R10 and R9: config write and new request during a walk
    v = '{3'd0, 32'h00010000, 32'h00020000, 32'h00700000, 32'h0001001C, 32'h77700002,
          32'h0, 32'h0, 32'h77700000, 2'd0, 1'b0, 2'd1, 2'd0, 2'd0};
    set_cfg(v);
    @(negedge clk);
    req_valid = 1'b1; req_va = v.va;
    @(negedge clk);
    req_va = 32'hFFF00000;
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h00030000;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(mem_req_addr_o === 32'h0001001C, "R10 addr kept", mem_req_addr_o, 32'h0001001C);
    chk(req_ready_o === 1'b0, "R9 busy ignores req", {31'd0, req_ready_o}, 32'd0);
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    req_valid = 1'b0;
    mem_rsp_valid = 1'b1; mem_rsp_data = v.d1;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk(res_valid_o && res_pa_o === 32'h77700000, "R10 result", res_pa_o, 32'h77700000);
    @(negedge clk);
    chk(req_ready_o && !mem_req_valid_o, "R9 no second walk",
        {30'd0, req_ready_o, mem_req_valid_o}, 32'd2);
    v.a1 = 32'h0003001C;
    do_walk(v, "R10 new base");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule